// File: doc/BRIEF.md
# MSI Cache Snoop Responder

This block is the coherence agent that sits between a processor and its private cache in a directory-based multiprocessor. Each cache line is held in one of three states: INVALID, SHARED or MODIFIED. A load that misses sends a READ that asks for a SHARED copy. A store to a line that is absent or only SHARED sends a READ that asks for a MODIFIED copy. The agent then waits for the home node's reply and installs the line in the state the reply grants. The home node of a line is fixed by the upper bits of its line address.

Coherence traffic from the home node arrives on a snoop port. An invalidation demotes the line to INVALID. A read aimed at the owner demotes a MODIFIED line to SHARED. Every snoop is answered with a WRITE that carries the line's state as it was before the demotion, and the answer is sent even when the line is absent. When a miss needs a way that holds a valid line, the agent first emits a WRITE for that victim (a writeback if it was MODIFIED) and then sends the READ. The tag and state array is set-associative with one LRU bit per set. The data array and the network are not part of this block.

Top module: `msi_snoop_agent`

## Requirements
- R1: After reset every line is INVALID, no message is issued, `snp_ready` is high and `cpu_done` is low.
- R2: A load to a line not held sends READ (`out_kind`=0) with tag SHARED (`out_tag`=1). The message is registered, so it appears in the cycle after the request is accepted. `out_dest` is the top NODE_W bits of the line address.
- R3: A store to a line held SHARED or not held sends READ with tag MODIFIED (`out_tag`=2). A store to a SHARED line sends no victim WRITE and uses the way it already occupies.
- R4: A load to a line held SHARED or MODIFIED, or a store to a line held MODIFIED, raises `cpu_done` in the same cycle, sends no message and marks that way most recently used.
- R5: An invalidation snoop (`snp_kind`=0) sets the line INVALID. It sends WRITE (`out_kind`=1) to the line's home node, tagged with the prior state, or INVALID (`out_tag`=0) if the line is not held.
- R6: An owner-read snoop (`snp_kind`=1) turns MODIFIED into SHARED and sends WRITE tagged MODIFIED. A SHARED line stays SHARED and is answered with tag SHARED. A line not held is answered with tag INVALID.
- R7: A miss takes the lowest-numbered INVALID way of its set, and otherwise the least recently used way. If the chosen way is valid, a WRITE tagged with its state goes out first and the READ follows one cycle later, unless a snoop takes that cycle.
- R8: A reply (`rsp_valid`) during an outstanding miss installs the line in the state given by `rsp_tag` and raises `cpu_done` in that cycle. A reply while no miss is outstanding is ignored.
- R9: A snoop takes precedence over a new processor request and over the READ still pending after a victim WRITE. A reply takes precedence over a snoop, and `snp_ready` is low while a reply is being taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present; held until `cpu_done` |
| cpu_store | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Line address of the request |
| cpu_done | output | 1 | Request completed this cycle |
| snp_valid | input | 1 | Snoop present |
| snp_kind | input | 1 | 0 = invalidate, 1 = owner read |
| snp_addr | input | ADDR_W | Line address of the snoop |
| snp_ready | output | 1 | Snoop accepted this cycle |
| rsp_valid | input | 1 | Reply from the home node for the outstanding miss |
| rsp_tag | input | 2 | Granted state: 1 = SHARED, 2 = MODIFIED |
| out_valid | output | 1 | Outgoing message valid (one-cycle pulse) |
| out_kind | output | 1 | 0 = READ, 1 = WRITE |
| out_tag | output | 2 | State tag: 0 INVALID, 1 SHARED, 2 MODIFIED |
| out_addr | output | ADDR_W | Line address of the message |
| out_dest | output | NODE_W | Home node of the line |

## Verification
The hardest situation to reach from the ports is a snoop that lands in the single cycle between a victim WRITE and its READ. It needs a full set, a valid LRU victim and a snoop that is timed to the cycle. The bench fills sets with a few tags that collide on purpose. It waits until it sees the victim WRITE and then drives the snoop on the next cycle. A second rare case is a reply and a snoop arriving in the same cycle. The bench creates it both directed and at random, and checks that the snoop is held back and then answered against the newly installed line.

// File: rtl/msi_pkg.sv
package msi_pkg;
   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHR = 2'd1,
      LN_MOD = 2'd2
   } line_state_e;

   typedef enum logic {
      MSG_READ  = 1'b0,
      MSG_WRITE = 1'b1
   } msg_kind_e;

   typedef enum logic {
      SNP_INVAL = 1'b0,
      SNP_OWNRD = 1'b1
   } snp_kind_e;

   typedef enum logic [1:0] {
      AG_IDLE  = 2'd0,
      AG_FETCH = 2'd1,
      AG_WAIT  = 2'd2
   } agent_fsm_e;
endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array #(
   parameter int SETS  = 16,
   parameter int WAYS  = 2,
   parameter int TAG_W = 8,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [SET_W-1:0]             rd_set,
   output logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
   output logic [WAYS-1:0][1:0]         rd_state,
   output logic [WAY_W-1:0]             rd_lru,
   input  logic                         wr_en,
   input  logic [SET_W-1:0]             wr_set,
   input  logic [WAY_W-1:0]             wr_way,
   input  logic [TAG_W-1:0]             wr_tag,
   input  logic [1:0]                   wr_state,
   input  logic                         use_en,
   input  logic [SET_W-1:0]             use_set,
   input  logic [WAY_W-1:0]             use_way
);
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [1:0]       state_q [SETS][WAYS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               state_q[s][w] <= 2'd0;
      end else if (wr_en) begin
         state_q[wr_set][wr_way] <= wr_state;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
   end

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         rd_tag[w]   = tag_q[rd_set][w];
         rd_state[w] = state_q[rd_set][w];
      end
   end

   generate
      if (WAYS == 2) begin : g_lru
         logic lru_q [SETS];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) lru_q[s] <= 1'b0;
            end else if (use_en) begin
               lru_q[use_set] <= ~use_way[0];
            end
         end
         assign rd_lru = lru_q[rd_set];
      end else begin : g_nolru
         assign rd_lru = '0;
      end
   endgenerate
endmodule

// File: rtl/msi_way_pick.sv
module msi_way_pick
   import msi_pkg::*;
#(
   parameter int WAYS  = 2,
   parameter int TAG_W = 8,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [TAG_W-1:0]             look_tag,
   input  logic [WAYS-1:0][TAG_W-1:0]   rd_tag,
   input  logic [WAYS-1:0][1:0]         rd_state,
   input  logic [WAY_W-1:0]             lru,
   output logic [WAYS-1:0]              hit_vec,
   output logic                         hit,
   output logic [WAY_W-1:0]             hit_way,
   output logic [1:0]                   hit_state,
   output logic [WAY_W-1:0]             victim_way,
   output logic [1:0]                   victim_state,
   output logic [TAG_W-1:0]             victim_tag
);
   genvar gw;
   generate
      for (gw = 0; gw < WAYS; gw++) begin : g_match
         assign hit_vec[gw] = (rd_state[gw] != LN_INV) && (rd_tag[gw] == look_tag);
      end
   endgenerate

   always_comb begin
      hit       = 1'b0;
      hit_way   = '0;
      hit_state = LN_INV;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            hit       = 1'b1;
            hit_way   = WAY_W'(w);
            hit_state = rd_state[w];
         end
      end
   end

   generate
      if (WAYS == 1) begin : g_direct
         assign victim_way = '0;
      end else begin : g_assoc
         logic             free;
         logic [WAY_W-1:0] free_way;
         always_comb begin
            free     = 1'b0;
            free_way = '0;
            for (int w = WAYS - 1; w >= 0; w--) begin
               if (rd_state[w] == LN_INV) begin
                  free     = 1'b1;
                  free_way = WAY_W'(w);
               end
            end
         end
         assign victim_way = free ? free_way : lru;
      end
   endgenerate

   assign victim_state = rd_state[victim_way];
   assign victim_tag   = rd_tag[victim_way];
endmodule

// File: rtl/msi_msg_reg.sv
module msi_msg_reg #(
   parameter int ADDR_W = 12,
   parameter int NODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              send,
   input  logic              kind,
   input  logic [1:0]        tag,
   input  logic [ADDR_W-1:0] addr,
   output logic              out_valid,
   output logic              out_kind,
   output logic [1:0]        out_tag,
   output logic [ADDR_W-1:0] out_addr,
   output logic [NODE_W-1:0] out_dest
);
   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= send;
   end

   always_ff @(posedge clk) begin
      if (send) begin
         out_kind <= kind;
         out_tag  <= tag;
         out_addr <= addr;
         out_dest <= addr[ADDR_W-1 -: NODE_W];
      end
   end
endmodule

// File: rtl/msi_snoop_agent.sv
module msi_snoop_agent
   import msi_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int SETS   = 16,
   parameter int WAYS   = 2,
   parameter int NODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_valid,
   input  logic              cpu_store,
   input  logic [ADDR_W-1:0] cpu_addr,
   output logic              cpu_done,
   input  logic              snp_valid,
   input  logic              snp_kind,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              snp_ready,
   input  logic              rsp_valid,
   input  logic [1:0]        rsp_tag,
   output logic              out_valid,
   output logic              out_kind,
   output logic [1:0]        out_tag,
   output logic [ADDR_W-1:0] out_addr,
   output logic [NODE_W-1:0] out_dest
);
   localparam int SET_W = $clog2(SETS);
   localparam int TAG_W = ADDR_W - SET_W;
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

   generate
      if (WAYS < 1 || WAYS > 2) begin : g_bad_ways
         $error("msi_snoop_agent: WAYS must be 1 or 2");
      end
      if ((1 << SET_W) != SETS) begin : g_bad_sets
         $error("msi_snoop_agent: SETS must be a power of two");
      end
      if (NODE_W < 1 || NODE_W > ADDR_W || TAG_W < 1) begin : g_bad_widths
         $error("msi_snoop_agent: address split does not fit");
      end
   endgenerate

   agent_fsm_e        fsm_q, fsm_d;
   logic [ADDR_W-1:0] miss_addr_q;
   logic [WAY_W-1:0]  miss_way_q, miss_way_d;
   logic              miss_store_q;
   logic              cap_miss;

   logic              serve_rsp, serve_snp, serve_cpu;
   logic [ADDR_W-1:0] look_addr;
   logic [SET_W-1:0]  look_set;
   logic [TAG_W-1:0]  look_tag;

   logic [WAYS-1:0][TAG_W-1:0] rd_tag;
   logic [WAYS-1:0][1:0]       rd_state;
   logic [WAY_W-1:0]           rd_lru;
   logic [WAYS-1:0]            hit_vec;
   logic                       hit;
   logic [WAY_W-1:0]           hit_way, victim_way;
   logic [1:0]                 hit_state, victim_state;
   logic [TAG_W-1:0]           victim_tag;

   logic                       wr_en, use_en;
   logic [WAY_W-1:0]           wr_way, use_way;
   logic [TAG_W-1:0]           wr_tag;
   logic [1:0]                 wr_state;

   logic                       send, s_kind;
   logic [1:0]                 s_tag;
   logic [ADDR_W-1:0]          s_addr;

   // arbitration: reply first, then snoop, then pending READ, then processor
   assign serve_rsp = (fsm_q == AG_WAIT) && rsp_valid;
   assign serve_snp = snp_valid && !serve_rsp;
   assign serve_cpu = (fsm_q == AG_IDLE) && cpu_valid && !snp_valid;
   assign snp_ready = !serve_rsp;

   assign look_addr = serve_rsp ? miss_addr_q : (snp_valid ? snp_addr : cpu_addr);
   assign look_set  = look_addr[SET_W-1:0];
   assign look_tag  = look_addr[ADDR_W-1:SET_W];

   msi_tag_array #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (look_set),
      .rd_tag   (rd_tag),
      .rd_state (rd_state),
      .rd_lru   (rd_lru),
      .wr_en    (wr_en),
      .wr_set   (look_set),
      .wr_way   (wr_way),
      .wr_tag   (wr_tag),
      .wr_state (wr_state),
      .use_en   (use_en),
      .use_set  (look_set),
      .use_way  (use_way)
   );

   msi_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W)) u_pick (
      .look_tag     (look_tag),
      .rd_tag       (rd_tag),
      .rd_state     (rd_state),
      .lru          (rd_lru),
      .hit_vec      (hit_vec),
      .hit          (hit),
      .hit_way      (hit_way),
      .hit_state    (hit_state),
      .victim_way   (victim_way),
      .victim_state (victim_state),
      .victim_tag   (victim_tag)
   );

   always_comb begin
      fsm_d      = fsm_q;
      miss_way_d = miss_way_q;
      cap_miss   = 1'b0;
      cpu_done   = 1'b0;
      send       = 1'b0;
      s_kind     = MSG_WRITE;
      s_tag      = LN_INV;
      s_addr     = look_addr;
      wr_en      = 1'b0;
      wr_way     = hit_way;
      wr_tag     = look_tag;
      wr_state   = LN_INV;
      use_en     = 1'b0;
      use_way    = hit_way;

      if (serve_rsp) begin
         wr_en    = 1'b1;
         wr_way   = miss_way_q;
         wr_state = rsp_tag;
         use_en   = 1'b1;
         use_way  = miss_way_q;
         cpu_done = 1'b1;
         fsm_d    = AG_IDLE;
      end else if (serve_snp) begin
         send   = 1'b1;
         s_kind = MSG_WRITE;
         s_tag  = hit ? hit_state : LN_INV;
         s_addr = snp_addr;
         if (hit) begin
            wr_en = 1'b1;
            if (snp_kind == SNP_INVAL)   wr_state = LN_INV;
            else if (hit_state == LN_MOD) wr_state = LN_SHR;
            else                          wr_state = hit_state;
         end
      end else if (fsm_q == AG_FETCH) begin
         send   = 1'b1;
         s_kind = MSG_READ;
         s_tag  = miss_store_q ? LN_MOD : LN_SHR;
         s_addr = miss_addr_q;
         fsm_d  = AG_WAIT;
      end else if (serve_cpu) begin
         if (hit && (!cpu_store || hit_state == LN_MOD)) begin
            cpu_done = 1'b1;
            use_en   = 1'b1;
         end else begin
            cap_miss   = 1'b1;
            miss_way_d = hit ? hit_way : victim_way;
            if (!hit && victim_state != LN_INV) begin
               send     = 1'b1;
               s_kind   = MSG_WRITE;
               s_tag    = victim_state;
               s_addr   = {victim_tag, look_set};
               wr_en    = 1'b1;
               wr_way   = victim_way;
               wr_tag   = victim_tag;
               wr_state = LN_INV;
               fsm_d    = AG_FETCH;
            end else begin
               send   = 1'b1;
               s_kind = MSG_READ;
               s_tag  = cpu_store ? LN_MOD : LN_SHR;
               s_addr = cpu_addr;
               fsm_d  = AG_WAIT;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) fsm_q <= AG_IDLE;
      else        fsm_q <= fsm_d;
   end

   always_ff @(posedge clk) begin
      if (cap_miss) begin
         miss_addr_q  <= cpu_addr;
         miss_store_q <= cpu_store;
      end
      miss_way_q <= miss_way_d;
   end

   msi_msg_reg #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .send      (send),
      .kind      (s_kind),
      .tag       (s_tag),
      .addr      (s_addr),
      .out_valid (out_valid),
      .out_kind  (out_kind),
      .out_tag   (out_tag),
      .out_addr  (out_addr),
      .out_dest  (out_dest)
   );
endmodule

// File: rtl/msi_agent_checker.sv
module msi_agent_checker
   import msi_pkg::*;
#(
   parameter int WAYS = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            snp_valid,
   input logic            snp_ready,
   input logic            rsp_valid,
   input logic            cpu_done,
   input logic            out_valid,
   input logic            out_kind,
   input logic [1:0]      out_tag,
   input logic [1:0]      fsm,
   input logic [WAYS-1:0] hit_vec
);
   // R5/R6: every accepted snoop is answered by a WRITE on the next cycle
   assert_snoop_answered_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_ready) |=> (out_valid && out_kind == MSG_WRITE));

   // R3: a READ never asks for INVALID
   assert_read_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_kind == MSG_READ) |-> (out_tag != LN_INV));

   // R4: completing a processor request produces no message
   assert_done_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !out_valid);

   // R9: a reply taken during a miss blocks the snoop port
   assert_reply_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm == AG_WAIT && rsp_valid) |-> !snp_ready);

   // R7: the READ follows the victim WRITE when no snoop intervenes
   assert_read_after_evict_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm == AG_FETCH && !snp_valid) |=> (out_valid && out_kind == MSG_READ));

   // R7: a line address is resident in at most one way
   assert_single_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

bind msi_snoop_agent msi_agent_checker #(.WAYS(WAYS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .snp_valid (snp_valid),
   .snp_ready (snp_ready),
   .rsp_valid (rsp_valid),
   .cpu_done  (cpu_done),
   .out_valid (out_valid),
   .out_kind  (out_kind),
   .out_tag   (out_tag),
   .fsm       (fsm_q),
   .hit_vec   (hit_vec)
);

// File: tb/msi_snoop_agent_bench.sv
`timescale 1ns/1ps
module msi_snoop_agent_bench;
   localparam int AW = 12;
   localparam int NW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_valid = 1'b0, cpu_store = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic          cpu_done;
   logic          snp_valid = 1'b0, snp_kind = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_ready;
   logic          rsp_valid = 1'b0;
   logic [1:0]    rsp_tag = 2'd0;
   logic          out_valid, out_kind;
   logic [1:0]    out_tag;
   logic [AW-1:0] out_addr;
   logic [NW-1:0] out_dest;

   always #2.5 clk = ~clk;

   msi_snoop_agent u_msi_snoop_agent (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid), .cpu_store(cpu_store), .cpu_addr(cpu_addr), .cpu_done(cpu_done),
      .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr), .snp_ready(snp_ready),
      .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
      .out_valid(out_valid), .out_kind(out_kind), .out_tag(out_tag),
      .out_addr(out_addr), .out_dest(out_dest)
   );

   int vecs = 0, errs = 0;
   int m_st  [16][2];
   int m_tag [16][2];
   int m_lru [16];

   function automatic int home(input logic [AW-1:0] a);
      return int'(a[AW-1 -: NW]);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_msg(input string req, input int kind, input int tag, input logic [AW-1:0] a);
      chk({req, " valid"}, int'(out_valid), 1);
      chk({req, " kind"},  int'(out_kind), kind);
      chk({req, " tag"},   int'(out_tag), tag);
      chk({req, " addr"},  int'(out_addr), int'(a));
      chk({req, " dest"},  int'(out_dest), home(a));
   endtask

   task automatic m_find(input logic [AW-1:0] a, output bit hit, output int way);
      int s = int'(a[3:0]);
      int t = int'(a[11:4]);
      hit = 0; way = 0;
      for (int w = 0; w < 2; w++)
         if (m_st[s][w] != 0 && m_tag[s][w] == t) begin hit = 1; way = w; end
   endtask

   task automatic model_snoop(input bit sk, input logic [AW-1:0] a, output int tagx);
      bit h; int w;
      int s = int'(a[3:0]);
      m_find(a, h, w);
      tagx = h ? m_st[s][w] : 0;
      if (h) begin
         if (!sk) m_st[s][w] = 0;
         else if (m_st[s][w] == 2) m_st[s][w] = 1;
      end
   endtask

   // R5 / R6: snoop from idle
   task automatic do_snoop(input bit sk, input logic [AW-1:0] a, input string req);
      int e;
      model_snoop(sk, a, e);
      snp_valid = 1'b1; snp_kind = sk; snp_addr = a;
      #1 chk({req, " snp_ready"}, int'(snp_ready), 1);
      @(negedge clk);
      snp_valid = 1'b0;
      chk_msg(req, 1, e, a);
   endtask

   // processor access; mid: 0 none, 1 snoop right after victim WRITE, 2 snoop while waiting
   task automatic cpu_op(input bit st, input logic [AW-1:0] a, input int mid,
                         input bit sk, input logic [AW-1:0] sa, input bit collide);
      bit h; int hw, way, e;
      bit ev;
      int s = int'(a[3:0]);
      int t = int'(a[11:4]);
      m_find(a, h, hw);
      cpu_valid = 1'b1; cpu_store = st; cpu_addr = a;
      #1;
      if (h && (!st || m_st[s][hw] == 2)) begin
         chk("R4 hit done", int'(cpu_done), 1);
         @(negedge clk);
         chk("R4 hit no message", int'(out_valid), 0);
         m_lru[s] = 1 - hw;
         cpu_valid = 1'b0;
         return;
      end
      chk(st ? "R3 miss not done" : "R2 miss not done", int'(cpu_done), 0);
      if (h) begin
         way = hw; ev = 0;
      end else begin
         way = (m_st[s][0] == 0) ? 0 : ((m_st[s][1] == 0) ? 1 : m_lru[s]);
         ev = (m_st[s][way] != 0);
      end
      if (ev) begin
         @(negedge clk);
         chk_msg("R7 victim WRITE", 1, m_st[s][way], {m_tag[s][way][7:0], a[3:0]});
         m_st[s][way] = 0;
         if (mid == 1) begin
            model_snoop(sk, sa, e);
            snp_valid = 1'b1; snp_kind = sk; snp_addr = sa;
            @(negedge clk);
            snp_valid = 1'b0;
            chk_msg("R9 snoop before pending READ", 1, e, sa);
         end
      end
      @(negedge clk);
      chk_msg(st ? "R3 READ modified" : "R2 READ shared", 0, st ? 2 : 1, a);
      if (mid == 2) begin
         model_snoop(sk, sa, e);
         snp_valid = 1'b1; snp_kind = sk; snp_addr = sa;
         @(negedge clk);
         snp_valid = 1'b0;
         chk_msg("R5 snoop during miss", 1, e, sa);
      end
      rsp_valid = 1'b1; rsp_tag = st ? 2'd2 : 2'd1;
      if (collide) begin
         snp_valid = 1'b1; snp_kind = sk; snp_addr = sa;
      end
      #1;
      chk("R8 reply completes", int'(cpu_done), 1);
      if (collide) chk("R9 reply blocks snoop", int'(snp_ready), 0);
      @(negedge clk);
      rsp_valid = 1'b0; cpu_valid = 1'b0;
      m_st[s][way] = st ? 2 : 1; m_tag[s][way] = t; m_lru[s] = 1 - way;
      chk("R8 reply sends nothing", int'(out_valid), 0);
      if (collide) begin
         model_snoop(sk, sa, e);
         @(negedge clk);
         snp_valid = 1'b0;
         chk_msg("R9 held snoop answered", 1, e, sa);
      end
   endtask

   initial begin
      #500000;
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      logic [AW-1:0] A, B, C, D;
      for (int s = 0; s < 16; s++) begin
         m_lru[s] = 0;
         for (int w = 0; w < 2; w++) begin m_st[s][w] = 0; m_tag[s][w] = 0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 out idle", int'(out_valid), 0);
      chk("R1 snp_ready", int'(snp_ready), 1);
      chk("R1 done low", int'(cpu_done), 0);
      @(negedge clk);

      A = 12'hA53; B = 12'h3C3; C = 12'hE13; D = 12'h773;
      cpu_op(0, A, 0, 0, 0, 0);          // R2 load miss on a reset array
      cpu_op(0, A, 0, 0, 0, 0);          // R4 load hit
      cpu_op(1, A, 0, 0, 0, 0);          // R3 store upgrade from SHARED
      cpu_op(1, A, 0, 0, 0, 0);          // R4 store hit on MODIFIED
      do_snoop(1, A, "R6 owner read on MODIFIED");
      do_snoop(1, A, "R6 owner read on SHARED");
      do_snoop(0, A, "R5 invalidate SHARED");
      do_snoop(0, A, "R5 invalidate absent");
      do_snoop(1, A, "R6 owner read absent");
      cpu_op(1, B, 0, 0, 0, 0);          // R3 store miss from INVALID
      cpu_op(0, C, 0, 0, 0, 0);
      cpu_op(0, B, 0, 0, 0, 0);          // C becomes LRU
      cpu_op(0, D, 0, 0, 0, 0);          // R7 evicts C
      cpu_op(1, A, 1, 1, B, 0);          // R7/R9 snoop in the gap after the victim WRITE
      cpu_op(0, C, 2, 0, D, 1);          // R9 collision of reply and snoop

      // R8: a stray reply while idle must not change anything
      rsp_valid = 1'b1; rsp_tag = 2'd2;
      #1 chk("R8 stray reply no done", int'(cpu_done), 0);
      @(negedge clk);
      rsp_valid = 1'b0;
      chk("R8 stray reply no message", int'(out_valid), 0);
      cpu_op(0, C, 0, 0, 0, 0);

      // R9: snoop wins over a simultaneous processor hit
      cpu_valid = 1'b1; cpu_store = 1'b0; cpu_addr = C;
      begin
         int e;
         model_snoop(1, A, e);
         snp_valid = 1'b1; snp_kind = 1'b1; snp_addr = A;
         #1 chk("R9 cpu held behind snoop", int'(cpu_done), 0);
         @(negedge clk);
         snp_valid = 1'b0; cpu_valid = 1'b0;
         chk_msg("R9 snoop served first", 1, e, A);
      end

      void'($urandom(32'd7321));
      for (int i = 0; i < 600; i++) begin
         int op = $urandom_range(0, 9);
         logic [AW-1:0] ra  = {8'($urandom_range(0, 4) * 8'h35), 4'($urandom_range(0, 1))};
         logic [AW-1:0] rsa = {8'($urandom_range(0, 4) * 8'h35), 4'($urandom_range(0, 1))};
         if (op < 6)
            cpu_op(1'($urandom_range(0, 1)), ra, $urandom_range(0, 2),
                   1'($urandom_range(0, 1)), rsa, ($urandom_range(0, 4) == 0));
         else
            do_snoop(1'($urandom_range(0, 1)), rsa, "R5/R6 random snoop");
      end

      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule